// File: doc/BRIEF.md
# Serial DAC Input Interface Controller

This block is the digital front end of a current-output multiplying converter. A host sends 16-bit words over a three-wire link: an active-low frame select, a serial clock and a data line. The block samples all three pins with its own faster system clock, finds the serial clock edges, and shifts the data into a 16-bit register, most significant bit first. When the frame select rises after exactly sixteen active edges, the word is decoded.

The two top bits of the word are a command. A load command moves the left-justified data field into an input latch. One system clock later, the latch value passes to the DAC register that drives the converter code. A configuration command chooses which serial clock edge captures data for later frames. The two remaining commands are reserved and change nothing. The code width is a parameter (8, 10 or 12). The frame is always 16 bits long, and the unused low bits are dropped.

Top module: `sdac_if_top`

## Requirements
- R1: While rst_ni is low, and after it is released, `in_latch_o` and `dac_code_o` are zero and data is captured on the falling serial clock edge.
- R2: A frame is shifted in MSB first. Bits [15:14] hold the command. The data field is bits [13:14-DATA_W], and for DATA_W below 14 the bits under it are ignored.
- R3: In falling-edge mode, the bit on the data line at each falling edge of `sclk_i` is captured, and its value at rising edges has no effect.
- R4: Command 2'b00 in a complete frame loads the data field into `in_latch_o`, and `dac_code_o` then takes that value.
- R5: Commands 2'b01 and 2'b10 leave `in_latch_o`, `dac_code_o` and the capture edge unchanged.
- R6: Command 2'b11 sets the capture edge from bit 13: 1 selects the rising edge and 0 selects the falling edge. The change applies from the next frame, and the latches are not changed.
- R7: A frame is acted on only if `sync_ni` rises after exactly 16 active edges. A frame with fewer or more edges is discarded.
- R8: `dac_code_o` takes the new latch value exactly one system clock after `in_latch_o` changes.
- R9: Serial clock edges while `sync_ni` is high are not counted and do not change any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_ni | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock, at most one fifth of clk_i |
| sdin_i | input | 1 | Serial data |
| in_latch_o | output | DATA_W | Input latch contents |
| dac_code_o | output | DATA_W | DAC register, the code that drives the converter |

## Verification
The assertions assume that the serial pins change slowly enough for the two-flop synchronizers to see every level. They also assume that data is steady across the synchronizer delay at each active edge, and that the frame select toggles only while the serial clock is at rest. The stimulus holds each serial clock phase for four system clocks and changes data only midway through a phase. It moves the rest level of the clock only while the frame select is high. Random words, random capture styles and frame lengths of 15, 16 or 17 edges are drawn inside these limits.

// File: rtl/sdac_if_pkg.sv
package sdac_if_pkg;
  localparam int FRAME_W = 16;
  typedef enum logic [1:0] {
    CMD_LOAD = 2'b00,
    CMD_RSV1 = 2'b01,
    CMD_RSV2 = 2'b10,
    CMD_EDGE = 2'b11
  } cmd_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_if_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_s_i,
  input  logic               sclk_s_i,
  input  logic               sdin_s_i,
  input  logic               rise_mode_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sclk_q, sync_q, act_edge;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shreg_q;

  assign act_edge = rise_mode_i ? (sclk_s_i & ~sclk_q) : (~sclk_s_i & sclk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      sync_q  <= 1'b1;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      sync_q <= sync_s_i;
      if (sync_s_i) begin
        cnt_q <= '0;
      end else if (act_edge) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], sdin_s_i};
        // saturate one past full so long frames stay rejected
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign frame_vld_o = sync_s_i & ~sync_q & (cnt_q == CNT_FULL);
  assign frame_o     = shreg_q;
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_if_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               rise_mode_o,
  output logic [DATA_W-1:0]  in_latch_o,
  output logic [DATA_W-1:0]  dac_code_o
);
  localparam int DATA_MSB = FRAME_W - 3;

  cmd_e cmd;
  logic load_q;

  assign cmd = cmd_e'(frame_i[FRAME_W-1 -: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_mode_o <= 1'b0;
      in_latch_o  <= '0;
      dac_code_o  <= '0;
      load_q      <= 1'b0;
    end else begin
      load_q <= frame_vld_i && (cmd == CMD_LOAD);
      if (frame_vld_i && cmd == CMD_LOAD) in_latch_o <= frame_i[DATA_MSB -: DATA_W];
      if (frame_vld_i && cmd == CMD_EDGE) rise_mode_o <= frame_i[DATA_MSB];
      if (load_q) dac_code_o <= in_latch_o;
    end
  end
endmodule

// File: rtl/sdac_if_top.sv
module sdac_if_top
  import sdac_if_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic [DATA_W-1:0] in_latch_o,
  output logic [DATA_W-1:0] dac_code_o
);
  logic [2:0]         pins_s;
  logic               rise_mode, frame_vld;
  logic [FRAME_W-1:0] frame;

  sdac_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sync_ni, sclk_i, sdin_i}),
    .q_o   (pins_s)
  );

  sdac_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_s_i   (pins_s[2]),
    .sclk_s_i   (pins_s[1]),
    .sdin_s_i   (pins_s[0]),
    .rise_mode_i(rise_mode),
    .frame_vld_o(frame_vld),
    .frame_o    (frame)
  );

  sdac_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_vld_i(frame_vld),
    .frame_i    (frame),
    .rise_mode_o(rise_mode),
    .in_latch_o (in_latch_o),
    .dac_code_o (dac_code_o)
  );
endmodule

// File: rtl/sdac_if_chk.sv
module sdac_if_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_vld,
  input logic [15:0]       frame,
  input logic              rise_mode,
  input logic [DATA_W-1:0] in_latch_o,
  input logic [DATA_W-1:0] dac_code_o
);
  always @(posedge clk_i)
    if (!rst_ni)
      AST_RESET_CLEAR: assert (in_latch_o == '0 && dac_code_o == '0 && !rise_mode); // R1

  AST_LATCH_TO_DAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(in_latch_o) |=> dac_code_o == $past(in_latch_o)); // R8

  AST_LATCH_ONLY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(in_latch_o) |-> $past(frame_vld && frame[15:14] == 2'b00)); // R4

  AST_RSV_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && (frame[15:14] == 2'b01 || frame[15:14] == 2'b10))
      |=> $stable(in_latch_o) && $stable(rise_mode)); // R5

  AST_EDGE_ONLY_ON_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rise_mode) |-> $past(frame_vld && frame[15:14] == 2'b11)); // R6
endmodule

bind sdac_if_top sdac_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_vld (frame_vld),
  .frame     (frame),
  .rise_mode (rise_mode),
  .in_latch_o(in_latch_o),
  .dac_code_o(dac_code_o)
);

// File: tb/sdac_if_top_test.sv
module sdac_if_top_test;
  localparam int W = 12;

  logic clk = 1'b0, rst_n = 1'b0, sync_n = 1'b1, sclk = 1'b1, sdin = 1'b0;
  logic [W-1:0] latch_o, dac_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic         m_rise = 1'b0;
  logic [W-1:0] m_latch = '0;

  always #4 clk = ~clk;

  sdac_if_top #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n), .sclk_i(sclk), .sdin_i(sdin),
    .in_latch_o(latch_o), .dac_code_o(dac_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // expected effect of a frame, from the requirements
  function automatic void model(input logic [15:0] word, input int nbits, input bit style);
    logic [15:0] cap;
    cap = (style == m_rise) ? word : ~word; // wrong edge sees inverted bits (R3)
    if (nbits != 16) return;                // R7
    case (cap[15:14])
      2'b00: m_latch = cap[13:2];           // R2 R4
      2'b11: m_rise = cap[13];              // R6
      default: ;                            // R5
    endcase
  endfunction

  // style 1 = active edge is rising; data is inverted after each active edge
  task automatic send(input logic [15:0] word, input int nbits, input bit style, input string req);
    logic [W-1:0] pl, pd;
    bit lagchk;
    sclk = style ? 1'b0 : 1'b1;
    wclk(6);
    sync_n = 1'b0;
    wclk(4);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 16) ? word[15-i] : 1'b0;
      sdin = b;
      wclk(4);
      sclk = ~sclk;
      wclk(2);
      sdin = ~b;
      wclk(2);
      sclk = ~sclk;
      wclk(2);
    end
    wclk(4);
    sync_n = 1'b1;
    @(negedge clk);
    pl = latch_o;
    pd = dac_o;
    lagchk = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!lagchk && latch_o != pl) begin
        lagchk = 1'b1;
        chk("R8 dac lags latch", dac_o, pd);
        @(negedge clk);
        chk("R8 dac follows", dac_o, latch_o);
      end
    end
    model(word, nbits, style);
    chk(req, latch_o, m_latch);
    chk(req, dac_o, m_latch);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    wclk(5);
    @(negedge clk);
    chk("R1 latch in reset", latch_o, 0);
    chk("R1 dac in reset", dac_o, 0);
    rst_n = 1'b1;
    wclk(3);
    @(negedge clk);
    chk("R1 latch after reset", latch_o, 0);

    send({2'b00, 12'hABC, 2'b11}, 16, 1'b0, "R4 R2 load falling default");
    send({2'b00, 12'h35A, 2'b00}, 16, 1'b0, "R4 R1 second load");
    send({2'b01, 14'h3FFF}, 16, 1'b0, "R5 code 01");
    send({2'b10, 14'h1234}, 16, 1'b0, "R5 code 10");
    send({2'b00, 12'h0F0, 2'b01}, 16, 1'b0, "R5 edge kept falling");
    send({2'b11, 14'h2AAA}, 16, 1'b1, "R3 rising edges ignored");
    send({2'b11, 1'b1, 13'h0}, 16, 1'b0, "R6 select rising");
    send({2'b00, 12'hC3D, 2'b10}, 16, 1'b1, "R6 rising load");
    send({2'b00, 12'h111, 2'b00}, 16, 1'b0, "R6 falling style in rising mode");
    send({2'b11, 1'b0, 13'h1FFF}, 16, 1'b1, "R6 back to falling");
    send({2'b00, 12'h777, 2'b00}, 16, 1'b0, "R6 falling again");
    send({2'b00, 12'h001, 2'b00}, 15, 1'b0, "R7 short frame");
    send({2'b00, 12'hFFE, 2'b00}, 17, 1'b0, "R7 long frame");

    for (int i = 0; i < 24; i++) begin // R9
      sdin = $urandom() % 2;
      sclk = ~sclk;
      wclk(4);
    end
    @(negedge clk);
    chk("R9 latch unchanged", latch_o, m_latch);
    chk("R9 dac unchanged", dac_o, m_latch);
    send({2'b00, 12'h5A5, 2'b00}, 16, 1'b0, "R9 clean frame after idle edges");

    for (int i = 0; i < 60; i++) begin
      logic [15:0] w;
      int r, n;
      bit st;
      w = 16'($urandom());
      r = $urandom() % 10;
      n = (r == 0) ? 15 : (r == 1) ? 17 : 16;
      st = ($urandom() % 8 == 0) ? ~m_rise : m_rise;
      send(w, n, st, "R2 R4 R7 random frame");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule